// File: doc/BRIEF.md
# Write-Update Snooping Cache Controller

This block keeps one processor's small direct-mapped cache coherent with its peers on a shared broadcast bus. Each line is one data word. Each line carries a coherence state: invalid, exclusive-clean, shared, or dirty. The processor issues single-word reads and writes through a valid/ready port and gets a registered response. Misses, write-backs and update broadcasts go out through a request/grant bus port. A separate snoop input presents every command that other caches place on the bus.

Lines that only this cache holds follow write-back rules, so processor writes to them stay local. A processor write to a shared line is written through as an update broadcast. The broadcast carries the address and the new word, and it refreshes every other copy and memory. When this cache snoops another cache's update for a line it holds, it takes the broadcast word.

When it snoops a read, it reports that it holds the line on a wired-OR shared response. If its copy is dirty, it also drives the line's data out so that the requester and memory receive it. Bus arbitration and memory sit outside the block.

Top module: `wu_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_req_ready_o` is high, and `bus_req_o`, `cpu_rsp_valid_o`, `snp_shared_o` and `snp_flush_o` are low.
- R2: A processor read that hits returns the cached word on `cpu_rsp_valid_o` one cycle after acceptance, and it raises no bus request.
- R3: A processor read that misses issues one read command (code 1) for the requested address. The line is installed shared if `bus_resp_shared_i` was high with the fill, and exclusive otherwise. The response carries the fill word.
- R4: A processor write that hits an exclusive or dirty line makes no bus request. The line becomes dirty and holds the new word, and the response echoes the written word.
- R5: A processor write that hits a shared line issues one update command (code 2) carrying the request address and the written word. The line stays shared and holds the new word.
- R6: A snooped update (code 2) that hits a held line asserts `snp_shared_o` in that cycle. The line takes the broadcast word and ends shared.
- R7: A snooped read (code 1) that hits a dirty line asserts `snp_flush_o` with the line's word on `snp_flush_data_o` and asserts `snp_shared_o`. The line becomes shared.
- R8: A snooped read that hits an exclusive or shared line asserts `snp_shared_o` but not `snp_flush_o`. The line becomes shared.
- R9: A snooped command whose address is not held, a snooped write-back (code 3), or an idle snoop input leaves `snp_shared_o` and `snp_flush_o` low.
- R10: A miss whose victim line is dirty first issues a write-back command (code 3) with the victim's address and word, and the read follows in the next cycle. A clean victim is dropped with no bus traffic.
- R11: `cpu_req_ready_o` is high only when no processor request is in progress and `snp_valid_i` is low, so a snoop wins over the processor for the line arrays.
- R12: A processor write that misses first fills the line by a read. It then completes as a write hit: silently to dirty after an exclusive fill, or by an update command after a shared fill.
- R13: While `bus_req_o` is high and not granted, `bus_cmd_o` and `bus_addr_o` hold their values. Each cycle with both `bus_req_o` and `bus_gnt_i` high is exactly one bus transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid_i | input | 1 | Processor request present |
| cpu_req_ready_o | output | 1 | Processor request accepted this cycle when valid |
| cpu_req_we_i | input | 1 | 1 = write, 0 = read |
| cpu_req_addr_i | input | ADDR_W | Word address of the request |
| cpu_req_wdata_i | input | DATA_W | Write word |
| cpu_rsp_valid_o | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata_o | output | DATA_W | Read word, or the written word for writes |
| bus_req_o | output | 1 | Bus transaction requested |
| bus_gnt_i | input | 1 | Bus granted; the transaction happens in this cycle |
| bus_cmd_o | output | 2 | 0 none, 1 read, 2 update, 3 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_data_o | output | DATA_W | Word for update or write-back |
| bus_resp_valid_i | input | 1 | Fill word for the outstanding read is present |
| bus_resp_data_i | input | DATA_W | Fill word |
| bus_resp_shared_i | input | 1 | Another cache holds the filled line |
| snp_valid_i | input | 1 | Another cache's command is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same coding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_data_i | input | DATA_W | Snooped update word |
| snp_shared_o | output | 1 | This cache holds the snooped line (wired-OR contribution) |
| snp_flush_o | output | 1 | This cache supplies the dirty line's word |
| snp_flush_data_o | output | DATA_W | Supplied word |

## Verification
The bench builds the controller with ADDR_W=8, DATA_W=16 and SETS=4, and it draws addresses from 24 words. Every set is then contested by six tags, so exclusive, dirty and shared victims turn up often, and dirty write-backs with their following reads are common. Snooped reads and updates land on lines that are still held, and withheld grants exercise the bus request hold rule.

// File: rtl/wu_snoop_pkg.sv
package wu_snoop_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_EXC = 2'd1,
        LS_SHR = 2'd2,
        LS_DRT = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_READ   = 2'd1,
        BC_UPDATE = 2'd2,
        BC_WBACK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        FS_IDLE  = 3'd0,
        FS_WBACK = 3'd1,
        FS_READ  = 3'd2,
        FS_WAIT  = 3'd3,
        FS_UPD   = 3'd4
    } ctl_fsm_e;

endpackage

// File: rtl/wu_line_lookup.sv
module wu_line_lookup
    import wu_snoop_pkg::*;
#(
    parameter int SETS   = 16,
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic [SETS-1:0][1:0]        st_i,
    input  logic [SETS-1:0][TAG_W-1:0]  tag_i,
    input  logic [SETS-1:0][DATA_W-1:0] dat_i,
    input  logic [IDX_W-1:0]            idx_i,
    input  logic [TAG_W-1:0]            tag_req_i,
    output logic                        hit_o,
    output line_st_e                    st_o,
    output logic [DATA_W-1:0]           dat_o
);

    logic [SETS-1:0] set_hit;

    // one comparator per set; only the addressed set can report a match
    for (genvar g = 0; g < SETS; g++) begin : g_set
        assign set_hit[g] = (idx_i == IDX_W'(g)) &&
                            (st_i[g] != LS_INV) &&
                            (tag_i[g] == tag_req_i);
    end

    assign hit_o = |set_hit;
    assign st_o  = line_st_e'(st_i[idx_i]);
    assign dat_o = dat_i[idx_i];

endmodule

// File: rtl/wu_snoop_resp.sv
module wu_snoop_resp
    import wu_snoop_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [DATA_W-1:0] snp_data_i,
    input  logic              hit_i,
    input  line_st_e          st_i,
    input  logic [DATA_W-1:0] line_dat_i,
    output logic              shared_o,
    output logic              flush_o,
    output logic [DATA_W-1:0] flush_dat_o,
    output logic              st_we_o,
    output line_st_e          st_o,
    output logic              dat_we_o,
    output logic [DATA_W-1:0] dat_o
);

    always_comb begin
        shared_o    = 1'b0;
        flush_o     = 1'b0;
        flush_dat_o = '0;
        st_we_o     = 1'b0;
        st_o        = st_i;
        dat_we_o    = 1'b0;
        dat_o       = line_dat_i;
        if (snp_valid_i && hit_i) begin
            case (snp_cmd_i)
                BC_READ: begin
                    shared_o = 1'b1;
                    st_we_o  = 1'b1;
                    st_o     = LS_SHR;
                    if (st_i == LS_DRT) begin
                        flush_o     = 1'b1;
                        flush_dat_o = line_dat_i;
                    end
                end
                BC_UPDATE: begin
                    shared_o = 1'b1;
                    st_we_o  = 1'b1;
                    st_o     = LS_SHR;
                    dat_we_o = 1'b1;
                    dat_o    = snp_data_i;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wu_snoop_ctrl.sv
module wu_snoop_ctrl
    import wu_snoop_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid_i,
    output logic              cpu_req_ready_o,
    input  logic              cpu_req_we_i,
    input  logic [ADDR_W-1:0] cpu_req_addr_i,
    input  logic [DATA_W-1:0] cpu_req_wdata_i,
    output logic              cpu_rsp_valid_o,
    output logic [DATA_W-1:0] cpu_rsp_rdata_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [1:0]        bus_cmd_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_data_o,
    input  logic              bus_resp_valid_i,
    input  logic [DATA_W-1:0] bus_resp_data_i,
    input  logic              bus_resp_shared_i,
    input  logic              snp_valid_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic [ADDR_W-1:0] snp_addr_i,
    input  logic [DATA_W-1:0] snp_data_i,
    output logic              snp_shared_o,
    output logic              snp_flush_o,
    output logic [DATA_W-1:0] snp_flush_data_o
);

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_fsm_e                    fsm;
        logic [SETS-1:0][1:0]        st;
        logic [SETS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][DATA_W-1:0] dat;
        logic                        we;
        logic [ADDR_W-1:0]           addr;
        logic [DATA_W-1:0]           wdata;
        logic                        rsp_v;
        logic [DATA_W-1:0]           rsp_d;
    } ctl_t;

    ctl_t r_d, r_q;

    // processor-side lookup: live request address when idle, held one otherwise
    logic [ADDR_W-1:0] lk_addr;
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    line_st_e          lk_st;
    logic [DATA_W-1:0] lk_dat;

    assign lk_addr = (r_q.fsm == FS_IDLE) ? cpu_req_addr_i : r_q.addr;
    assign lk_idx  = lk_addr[IDX_W-1:0];
    assign lk_tag  = lk_addr[ADDR_W-1:IDX_W];

    wu_line_lookup #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_cpu_lookup (
        .st_i      (r_q.st),
        .tag_i     (r_q.tag),
        .dat_i     (r_q.dat),
        .idx_i     (lk_idx),
        .tag_req_i (lk_tag),
        .hit_o     (lk_hit),
        .st_o      (lk_st),
        .dat_o     (lk_dat)
    );

    // snoop-side lookup and response
    logic [IDX_W-1:0]  sn_idx;
    logic [TAG_W-1:0]  sn_tag;
    logic              sn_hit;
    line_st_e          sn_cur_st;
    logic [DATA_W-1:0] sn_cur_dat;
    logic              sn_st_we;
    line_st_e          sn_new_st;
    logic              sn_dat_we;
    logic [DATA_W-1:0] sn_new_dat;

    assign sn_idx = snp_addr_i[IDX_W-1:0];
    assign sn_tag = snp_addr_i[ADDR_W-1:IDX_W];

    wu_line_lookup #(
        .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_snp_lookup (
        .st_i      (r_q.st),
        .tag_i     (r_q.tag),
        .dat_i     (r_q.dat),
        .idx_i     (sn_idx),
        .tag_req_i (sn_tag),
        .hit_o     (sn_hit),
        .st_o      (sn_cur_st),
        .dat_o     (sn_cur_dat)
    );

    wu_snoop_resp #(
        .DATA_W(DATA_W)
    ) u_snp_resp (
        .snp_valid_i (snp_valid_i),
        .snp_cmd_i   (snp_cmd_i),
        .snp_data_i  (snp_data_i),
        .hit_i       (sn_hit),
        .st_i        (sn_cur_st),
        .line_dat_i  (sn_cur_dat),
        .shared_o    (snp_shared_o),
        .flush_o     (snp_flush_o),
        .flush_dat_o (snp_flush_data_o),
        .st_we_o     (sn_st_we),
        .st_o        (sn_new_st),
        .dat_we_o    (sn_dat_we),
        .dat_o       (sn_new_dat)
    );

    logic [IDX_W-1:0] p_idx;
    logic [TAG_W-1:0] p_tag;
    logic             accept;

    assign p_idx           = r_q.addr[IDX_W-1:0];
    assign p_tag           = r_q.addr[ADDR_W-1:IDX_W];
    assign cpu_req_ready_o = (r_q.fsm == FS_IDLE) && !snp_valid_i;
    assign accept          = cpu_req_valid_i && cpu_req_ready_o;

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;

        // snoop effects first; the processor side below is newer and wins
        if (sn_st_we)  r_d.st[sn_idx]  = sn_new_st;
        if (sn_dat_we) r_d.dat[sn_idx] = sn_new_dat;

        case (r_q.fsm)
            FS_IDLE: begin
                if (accept) begin
                    r_d.we    = cpu_req_we_i;
                    r_d.addr  = cpu_req_addr_i;
                    r_d.wdata = cpu_req_wdata_i;
                    if (lk_hit) begin
                        if (!cpu_req_we_i) begin
                            r_d.rsp_v = 1'b1;
                            r_d.rsp_d = lk_dat;
                        end else if (lk_st == LS_SHR) begin
                            r_d.fsm = FS_UPD;
                        end else begin
                            r_d.st[lk_idx]  = LS_DRT;
                            r_d.dat[lk_idx] = cpu_req_wdata_i;
                            r_d.rsp_v       = 1'b1;
                            r_d.rsp_d       = cpu_req_wdata_i;
                        end
                    end else if (lk_st == LS_DRT) begin
                        r_d.fsm = FS_WBACK;
                    end else begin
                        r_d.fsm = FS_READ;
                    end
                end
            end
            FS_WBACK: begin
                if (bus_gnt_i) begin
                    r_d.st[p_idx] = LS_INV;
                    r_d.fsm       = FS_READ;
                end
            end
            FS_READ: begin
                if (bus_gnt_i) begin
                    r_d.st[p_idx] = LS_INV;
                    r_d.fsm       = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (bus_resp_valid_i) begin
                    r_d.tag[p_idx] = p_tag;
                    r_d.dat[p_idx] = bus_resp_data_i;
                    r_d.st[p_idx]  = bus_resp_shared_i ? LS_SHR : LS_EXC;
                    r_d.fsm        = FS_IDLE;
                    if (!r_q.we) begin
                        r_d.rsp_v = 1'b1;
                        r_d.rsp_d = bus_resp_data_i;
                    end else if (bus_resp_shared_i) begin
                        r_d.fsm = FS_UPD;
                    end else begin
                        r_d.st[p_idx]  = LS_DRT;
                        r_d.dat[p_idx] = r_q.wdata;
                        r_d.rsp_v      = 1'b1;
                        r_d.rsp_d      = r_q.wdata;
                    end
                end
            end
            FS_UPD: begin
                if (bus_gnt_i) begin
                    r_d.dat[p_idx] = r_q.wdata;
                    r_d.st[p_idx]  = LS_SHR;
                    r_d.rsp_v      = 1'b1;
                    r_d.rsp_d      = r_q.wdata;
                    r_d.fsm        = FS_IDLE;
                end
            end
            default: r_d.fsm = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cpu_rsp_valid_o = r_q.rsp_v;
    assign cpu_rsp_rdata_o = r_q.rsp_d;

    always_comb begin
        bus_req_o  = 1'b0;
        bus_cmd_o  = BC_NONE;
        bus_addr_o = r_q.addr;
        bus_data_o = '0;
        case (r_q.fsm)
            FS_WBACK: begin
                bus_req_o  = 1'b1;
                bus_cmd_o  = BC_WBACK;
                bus_addr_o = {r_q.tag[p_idx], p_idx};
                bus_data_o = lk_dat;
            end
            FS_READ: begin
                bus_req_o = 1'b1;
                bus_cmd_o = BC_READ;
            end
            FS_UPD: begin
                bus_req_o  = 1'b1;
                bus_cmd_o  = BC_UPDATE;
                bus_data_o = r_q.wdata;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/wu_snoop_ctrl_chk.sv
module wu_snoop_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_ready_o,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic [1:0]        bus_cmd_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              snp_valid_i,
    input logic              snp_shared_o,
    input logic              snp_flush_o
);

    p_flush_with_shared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush_o |-> snp_shared_o);

    p_quiet_snoop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid_i |-> (!snp_shared_o && !snp_flush_o));

    p_snoop_blocks_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid_i |-> !cpu_req_ready_o);

    p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_cmd_o) && $stable(bus_addr_o)));

    p_wback_then_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_gnt_i && bus_cmd_o == 2'd3) |=> (bus_req_o && bus_cmd_o == 2'd1));

endmodule

bind wu_snoop_ctrl wu_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req_ready_o (cpu_req_ready_o),
    .bus_req_o       (bus_req_o),
    .bus_gnt_i       (bus_gnt_i),
    .bus_cmd_o       (bus_cmd_o),
    .bus_addr_o      (bus_addr_o),
    .snp_valid_i     (snp_valid_i),
    .snp_shared_o    (snp_shared_o),
    .snp_flush_o     (snp_flush_o)
);

// File: tb/wu_snoop_ctrl_test.sv
module wu_snoop_ctrl_test;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NS = 4;
    localparam int ST_I = 0, ST_E = 1, ST_S = 2, ST_D = 3;
    localparam int C_RD = 1, C_UPD = 2, C_WB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0, cpu_req_ready, cpu_req_we = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          bus_req, bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          bus_resp_valid = 1'b0, bus_resp_shared = 1'b0;
    logic [DW-1:0] bus_resp_data = '0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_shared, snp_flush;
    logic [DW-1:0] snp_flush_data;

    int n_chk = 0;
    int n_bad = 0;

    int            m_st [NS];
    int            m_tag[NS];
    logic [DW-1:0] m_dat[NS];
    logic [DW-1:0] mem  [1 << AW];

    always #2 clk = ~clk;

    wu_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid_i(cpu_req_valid), .cpu_req_ready_o(cpu_req_ready),
        .cpu_req_we_i(cpu_req_we), .cpu_req_addr_i(cpu_req_addr),
        .cpu_req_wdata_i(cpu_req_wdata),
        .cpu_rsp_valid_o(cpu_rsp_valid), .cpu_rsp_rdata_o(cpu_rsp_rdata),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd),
        .bus_addr_o(bus_addr), .bus_data_o(bus_data),
        .bus_resp_valid_i(bus_resp_valid), .bus_resp_data_i(bus_resp_data),
        .bus_resp_shared_i(bus_resp_shared),
        .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
        .snp_data_i(snp_data), .snp_shared_o(snp_shared), .snp_flush_o(snp_flush),
        .snp_flush_data_o(snp_flush_data)
    );

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // processor request plus the behavioural bus/memory around it
    task automatic cpu_op(input bit we, input int a, input logic [DW-1:0] wd, input bit shr);
        int            idx = a % NS;
        int            tg = a / NS;
        bit            hit = (m_st[idx] != ST_I) && (m_tag[idx] == tg);
        int            ne = 0;
        int            na = 0;
        int            e_cmd[3];
        int            e_addr[3];
        logic [DW-1:0] e_dat[3];
        int            a_cmd[4];
        int            a_addr[4];
        logic [DW-1:0] a_dat[4];
        logic [DW-1:0] e_rsp;
        logic [DW-1:0] got_d = '0;
        bit            got = 0, pend = 0, hold = 0;
        int            pa = 0;
        logic [1:0]    h_cmd = '0;
        logic [AW-1:0] h_addr = '0;
        string         rq;
        if (hit) begin
            if (!we) begin
                rq = "R2"; e_rsp = m_dat[idx];
            end else if (m_st[idx] == ST_S) begin
                rq = "R5";
                e_cmd[0] = C_UPD; e_addr[0] = a; e_dat[0] = wd; ne = 1;
                m_dat[idx] = wd; e_rsp = wd;
            end else begin
                rq = "R4"; m_st[idx] = ST_D; m_dat[idx] = wd; e_rsp = wd;
            end
        end else begin
            rq = we ? "R12" : "R3";
            if (m_st[idx] == ST_D) begin
                rq = "R10";
                e_cmd[ne] = C_WB; e_addr[ne] = m_tag[idx] * NS + idx; e_dat[ne] = m_dat[idx]; ne++;
            end
            e_cmd[ne] = C_RD; e_addr[ne] = a; e_dat[ne] = '0; ne++;
            m_tag[idx] = tg; m_dat[idx] = mem[a]; m_st[idx] = shr ? ST_S : ST_E;
            if (!we) e_rsp = m_dat[idx];
            else if (shr) begin
                e_cmd[ne] = C_UPD; e_addr[ne] = a; e_dat[ne] = wd; ne++;
                m_dat[idx] = wd; e_rsp = wd;
            end else begin
                m_st[idx] = ST_D; m_dat[idx] = wd; e_rsp = wd;
            end
        end

        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_we = we;
        cpu_req_addr = AW'(a); cpu_req_wdata = wd;
        #1;
        check(cpu_req_ready == 1'b1, "R11 ready when idle", 32'(cpu_req_ready), 32'd1);
        @(posedge clk);
        for (int it = 0; it < 40 && !got; it++) begin
            @(negedge clk);
            cpu_req_valid  = 1'b0;
            bus_resp_valid = 1'b0;
            if (pend) begin
                bus_resp_valid = 1'b1; bus_resp_data = mem[pa]; bus_resp_shared = shr; pend = 0;
            end
            if (hold) begin
                check(bus_req && bus_cmd == h_cmd && bus_addr == h_addr,
                      "R13 request held", {bus_req, 6'd0, bus_cmd, 8'd0, bus_addr},
                      {1'b1, 6'd0, h_cmd, 8'd0, h_addr});
                hold = 0;
            end
            if (cpu_rsp_valid) begin
                got = 1; got_d = cpu_rsp_rdata; bus_gnt = 1'b0;
            end else if (bus_req) begin
                if ($urandom_range(0, 2) == 0) begin
                    bus_gnt = 1'b0; hold = 1; h_cmd = bus_cmd; h_addr = bus_addr;
                end else begin
                    bus_gnt = 1'b1;
                    if (na < 4) begin
                        a_cmd[na] = int'(bus_cmd); a_addr[na] = int'(bus_addr); a_dat[na] = bus_data;
                    end
                    na++;
                    if (bus_cmd == 2'(C_RD)) begin
                        pend = 1; pa = int'(bus_addr);
                    end else begin
                        mem[bus_addr] = bus_data;
                    end
                end
            end else begin
                bus_gnt = 1'b0;
            end
        end
        bus_gnt = 1'b0;
        check(got, {rq, " response arrived"}, 32'(got), 32'd1);
        check(na == ne, {rq, " bus transaction count"}, 32'(na), 32'(ne));
        for (int i = 0; i < ne && i < na; i++) begin
            check(a_cmd[i] == e_cmd[i], {rq, " bus command"}, 32'(a_cmd[i]), 32'(e_cmd[i]));
            check(a_addr[i] == e_addr[i], {rq, " bus address"}, 32'(a_addr[i]), 32'(e_addr[i]));
            if (e_cmd[i] != C_RD)
                check(a_dat[i] == e_dat[i], {rq, " bus data"}, 32'(a_dat[i]), 32'(e_dat[i]));
        end
        check(got_d == e_rsp, {rq, " response data"}, 32'(got_d), 32'(e_rsp));
    endtask

    task automatic snoop(input int cmd, input int a, input logic [DW-1:0] d);
        int    idx = a % NS;
        bit    hit = (m_st[idx] != ST_I) && (m_tag[idx] == a / NS);
        bit    e_sh = hit && (cmd == C_RD || cmd == C_UPD);
        bit    e_fl = hit && cmd == C_RD && m_st[idx] == ST_D;
        string rq;
        if (!hit || cmd == C_WB) rq = "R9";
        else if (cmd == C_UPD)   rq = "R6";
        else if (e_fl)           rq = "R7";
        else                     rq = "R8";
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 2'(cmd); snp_addr = AW'(a); snp_data = d;
        #1;
        check(snp_shared == e_sh, {rq, " shared response"}, 32'(snp_shared), 32'(e_sh));
        check(snp_flush == e_fl, {rq, " flush"}, 32'(snp_flush), 32'(e_fl));
        if (e_fl)
            check(snp_flush_data == m_dat[idx], "R7 flush data", 32'(snp_flush_data), 32'(m_dat[idx]));
        check(cpu_req_ready == 1'b0, "R11 snoop blocks processor", 32'(cpu_req_ready), 32'd0);
        if (hit && cmd == C_RD) begin
            if (m_st[idx] == ST_D) mem[a] = m_dat[idx];
            m_st[idx] = ST_S;
        end
        if (hit && cmd == C_UPD) begin
            m_st[idx] = ST_S; m_dat[idx] = d;
        end
        if (cmd == C_UPD) mem[a] = d;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL R13 watchdog: run hung actual=running expected=finished");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 37 + 5);
        for (int i = 0; i < NS; i++) begin
            m_st[i] = ST_I; m_tag[i] = 0; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cpu_req_ready == 1'b1, "R1 ready after reset", 32'(cpu_req_ready), 32'd1);
        check(bus_req == 1'b0, "R1 no bus request", 32'(bus_req), 32'd0);
        check(cpu_rsp_valid == 1'b0, "R1 no response", 32'(cpu_rsp_valid), 32'd0);
        check(snp_shared == 1'b0 && snp_flush == 1'b0, "R1 snoop outputs low",
              32'({snp_shared, snp_flush}), 32'd0);

        // directed corners
        cpu_op(1'b0, 5, '0, 1'b0);          // R3 miss -> exclusive
        cpu_op(1'b0, 5, '0, 1'b0);          // R2 hit
        cpu_op(1'b1, 5, 16'hBEEF, 1'b0);    // R4 exclusive -> dirty
        snoop(C_RD, 5, '0);                 // R7 flush, dirty -> shared
        cpu_op(1'b1, 5, 16'h1234, 1'b0);    // R5 update broadcast
        snoop(C_UPD, 5, 16'h5A5A);          // R6 take broadcast word
        cpu_op(1'b0, 5, '0, 1'b0);          // R2/R6 hit returns broadcast word
        cpu_op(1'b0, 6, '0, 1'b1);          // R3 miss -> shared
        cpu_op(1'b1, 10, 16'h0A0A, 1'b0);   // R12/R10 clean victim, exclusive fill -> dirty
        cpu_op(1'b0, 14, '0, 1'b0);         // R10 dirty victim write-back then read
        cpu_op(1'b0, 3, '0, 1'b0);          // R3 exclusive
        snoop(C_RD, 3, '0);                 // R8 exclusive -> shared
        cpu_op(1'b1, 3, 16'h3333, 1'b0);    // R5 after R8
        snoop(C_RD, 19, '0);                // R9 miss
        snoop(C_WB, 21, 16'h1111);          // R9 write-back never answered
        cpu_op(1'b1, 17, 16'h7777, 1'b1);   // R12 shared fill -> update

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 9);
            int a = $urandom_range(0, 23);
            if (r < 6) begin
                cpu_op(r < 3, a, DW'($urandom), 1'($urandom_range(0, 1)));
            end else begin
                int  c = $urandom_range(1, 3);
                int  ix = a % NS;
                bit  h = (m_st[ix] != ST_I) && (m_tag[ix] == a / NS);
                if (h && (c == C_WB || (c == C_UPD && m_st[ix] != ST_S))) c = C_RD;
                snoop(c, a, DW'($urandom));
            end
        end
        summary();
    end

endmodule